// File: doc/BRIEF.md
# USB Receive Endpoint Control and Status

This block holds the control and status byte for one USB receive endpoint. It works in peripheral mode and in host mode. It also tracks how many packets sit in a receive FIFO of one or two buffers. The packet engine reports events through single-cycle strobes:

- a packet was stored, and whether it had a CRC or bit-stuff fault;
- a STALL handshake was sent or received;
- an OUT packet was refused because no space was left.

A processor reads the byte and writes it whole through a simple read/write port. Most bits have hardware side effects.

The block drives these outputs:

- an interrupt pulse;
- the STALL request for the endpoint;
- a pulse that starts an IN transaction in host mode;
- the current data-toggle value;
- a one-cycle flush strobe that tells the FIFO to drop its newest packet and reset its pointer.

The error flags count only when the endpoint is isochronous. Bit 5 and bit 6 change meaning with the host/peripheral mode input.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset every bit of `rd_data` is 0, and `irq`, `stall_req`, `in_req`, `fifo_flush` and `data_toggle` are 0.
- R2: An accepted packet sets bit 0 (packet-ready) one clock edge later. `irq` is high for exactly the one cycle in which packet-ready first reads 1.
- R3: The block counts stored packets up to `BUF_DEPTH`. Bit 1 (FIFO-full) reads 1 when the count equals `BUF_DEPTH`. A packet that arrives while the FIFO is full, with no unload in the same cycle, is dropped and leaves all state unchanged.
- R4: A write with bit 4 set pulses `fifo_flush` for one cycle and removes one stored packet. With two stored packets, two flushes are needed to clear packet-ready. Bits 4 and 7 always read 0.
- R5: `data_toggle` inverts on every accepted packet. A write with bit 7 set forces it to 0, and this wins over a packet in the same cycle.
- R6: In isochronous mode, a faulty accepted packet sets bit 3 (data-error), and bit 3 clears when the packet count returns to 0. Bit 3 reads 0 in bulk mode and cannot be written.
- R7: In isochronous mode a refused packet sets bit 2 (overrun), and a write with bit 2 at 0 clears it. A refusal in the same cycle as a clearing write leaves bit 2 set. Bit 2 reads 0 in bulk mode.
- R8: In peripheral mode, bit 5 (send-stall) is written by software and drives `stall_req`. In isochronous mode `stall_req` stays 0 whatever bit 5 holds.
- R9: In peripheral mode, a sent STALL sets bit 6, and a write with bit 6 at 0 clears it. A STALL event in the same cycle as a clearing write leaves bit 6 set.
- R10: In host mode, a write with bit 5 set makes bit 5 read 1 and pulses `in_req` for one cycle. The next accepted packet clears bit 5.
- R11: In host mode, a received STALL sets bit 6 and raises a one-cycle `irq`, and a write with bit 6 at 0 clears it. In peripheral mode a received-STALL strobe is ignored.
- R12: Any write with bit 0 at 0 while a packet is stored unloads one packet. When this happens in the same cycle as a packet arrival, the count is unchanged and no new `irq` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host, 0 = peripheral |
| iso_mode | input | 1 | 1 = isochronous endpoint, 0 = bulk |
| ev_pkt | input | 1 | Packet engine stored a packet |
| ev_pkt_bad | input | 1 | The packet strobed with `ev_pkt` had a CRC or bit-stuff fault |
| ev_stall_tx | input | 1 | A STALL handshake was transmitted |
| ev_stall_rx | input | 1 | A STALL handshake was received |
| ev_reject | input | 1 | An OUT packet could not be loaded into the FIFO |
| wr_en | input | 1 | Processor writes `wr_data` to the register this cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| irq | output | 1 | Interrupt pulse |
| stall_req | output | 1 | Endpoint must answer with STALL |
| in_req | output | 1 | One-cycle request to start an IN transaction |
| data_toggle | output | 1 | Current data toggle |
| fifo_flush | output | 1 | One-cycle flush / pointer-reset strobe to the FIFO |

## Verification
The bench builds the block with `BUF_DEPTH` = 2, the double-buffered case.

This depth makes several cases reachable:
- a second packet stacking on the first;
- the FIFO-full flag;
- a third packet being dropped;
- the two-flush sequence needed to clear packet-ready.

With this depth, an unload and an arrival in the same cycle can also be exercised at a count of 1 without reaching the full limit. That isolates the rule that the count and the interrupt stay unchanged.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;

    // Bit positions inside the register byte
    localparam int B_RDY   = 0;
    localparam int B_FULL  = 1;
    localparam int B_OVR   = 2;
    localparam int B_DERR  = 3;
    localparam int B_FLUSH = 4;
    localparam int B_REQ   = 5;
    localparam int B_STALL = 6;
    localparam int B_CLRT  = 7;

    typedef struct packed {
        logic ovr;
        logic derr;
        logic b5;
        logic b6;
        logic tog;
        logic flush;
        logic inreq;
    } ep_state_t;

endpackage

// File: rtl/rxep_pkt_count.sv
module rxep_pkt_count #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic taken,
    output logic any,
    output logic full,
    output logic empty_next
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             drop;

    always_comb begin
        drop       = dec && (cnt_q != '0);
        taken      = inc && ((cnt_q < CNT_W'(DEPTH)) || drop);
        cnt_d      = cnt_q + CNT_W'(taken) - CNT_W'(drop);
        empty_next = (cnt_d == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign any  = (cnt_q != '0);
    assign full = (cnt_q == CNT_W'(DEPTH));

    // R3: the count never passes the buffer depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/rxep_rise.sv
module rxep_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign pulse = lvl && !prev_q;

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
    import usb_rx_ep_pkg::*;
#(
    parameter int BUF_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_mode,
    input  logic       iso_mode,
    input  logic       ev_pkt,
    input  logic       ev_pkt_bad,
    input  logic       ev_stall_tx,
    input  logic       ev_stall_rx,
    input  logic       ev_reject,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq,
    output logic       stall_req,
    output logic       in_req,
    output logic       data_toggle,
    output logic       fifo_flush
);
    ep_state_t st_d, st_q;

    logic unload, taken, pkt_any, pkt_full, empty_next;
    logic stall_set, rdy_irq, stall_irq;

    // Unload one packet on a flush or on a write that clears packet-ready
    assign unload = wr_en && (wr_data[B_FLUSH] || !wr_data[B_RDY]);

    rxep_pkt_count #(.DEPTH(BUF_DEPTH)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (ev_pkt),
        .dec        (unload),
        .taken      (taken),
        .any        (pkt_any),
        .full       (pkt_full),
        .empty_next (empty_next)
    );

    always_comb begin
        st_d      = st_q;
        stall_set = host_mode ? ev_stall_rx : ev_stall_tx;

        // Overrun: hardware set beats software clear
        if (ev_reject && iso_mode)            st_d.ovr = 1'b1;
        else if (wr_en && !wr_data[B_OVR])    st_d.ovr = 1'b0;

        // Data error follows the stored packets
        if (taken && ev_pkt_bad && iso_mode)  st_d.derr = 1'b1;
        else if (empty_next)                  st_d.derr = 1'b0;

        // Bit 5: send-stall or request-packet; a write wins over self-clear
        if (wr_en)                            st_d.b5 = wr_data[B_REQ];
        else if (host_mode && taken)          st_d.b5 = 1'b0;

        // Bit 6: stall sent / received
        if (stall_set)                        st_d.b6 = 1'b1;
        else if (wr_en && !wr_data[B_STALL])  st_d.b6 = 1'b0;

        // Data toggle
        if (wr_en && wr_data[B_CLRT])         st_d.tog = 1'b0;
        else if (taken)                       st_d.tog = !st_q.tog;

        st_d.flush = wr_en && wr_data[B_FLUSH];
        st_d.inreq = wr_en && wr_data[B_REQ] && host_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxep_rise u_rdy_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pkt_any),
        .pulse (rdy_irq)
    );

    rxep_rise u_stall_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (st_q.b6 && host_mode),
        .pulse (stall_irq)
    );

    assign irq         = rdy_irq || stall_irq;
    assign stall_req   = st_q.b5 && !host_mode && !iso_mode;
    assign in_req      = st_q.inreq;
    assign data_toggle = st_q.tog;
    assign fifo_flush  = st_q.flush;
    assign rd_data     = {1'b0, st_q.b6, st_q.b5, 1'b0,
                          st_q.derr && iso_mode, st_q.ovr && iso_mode,
                          pkt_full, pkt_any};

    // R2: packet-ready rising always comes with an interrupt
    a_r2_ready_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[B_RDY]) |-> irq);

    // R4: a flush strobe only follows a write with bit 4 set
    a_r4_flush_src: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> $past(wr_en && wr_data[B_FLUSH]));

    // R5: clear-toggle write leaves the toggle at 0
    a_r5_toggle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_CLRT]) |=> !data_toggle);

    // R6: data-error only visible while a packet is held
    a_r6_err_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[B_DERR] |-> rd_data[B_RDY]);

    // R9: a transmitted STALL in peripheral mode is never lost to a write
    a_r9_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stall_tx && !host_mode) |=> rd_data[B_STALL]);

    // R10: IN request pulse only after a host-mode bit 5 write
    a_r10_inreq_src: assert property (@(posedge clk) disable iff (!rst_n)
        in_req |-> $past(wr_en && wr_data[B_REQ] && host_mode));

endmodule

// File: tb/usb_rx_ep_ctrl_tb.sv
`timescale 1ns/1ps
module usb_rx_ep_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_mode = 0, iso_mode = 0;
    logic       ev_pkt = 0, ev_pkt_bad = 0, ev_stall_tx = 0, ev_stall_rx = 0, ev_reject = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq, stall_req, in_req, data_toggle, fifo_flush;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    usb_rx_ep_ctrl #(.BUF_DEPTH(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .iso_mode(iso_mode),
        .ev_pkt(ev_pkt), .ev_pkt_bad(ev_pkt_bad), .ev_stall_tx(ev_stall_tx),
        .ev_stall_rx(ev_stall_rx), .ev_reject(ev_reject), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .stall_req(stall_req),
        .in_req(in_req), .data_toggle(data_toggle), .fifo_flush(fifo_flush)
    );

    typedef struct packed {
        logic       we;
        logic [7:0] wd;
        logic       host;
        logic       iso;
        logic       pkt;
        logic       bad;
        logic       stx;
        logic       srx;
        logic       rej;
        logic [7:0] rd;
        logic       irq;
        logic       stl;
        logic       inr;
        logic       tog;
        logic       fl;
    } vec_t;

    localparam int NV = 30;
    // we wd host iso pkt bad stx srx rej | rd irq stl inr tog fl
    localparam vec_t TBL [NV] = '{
        '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}, // R1 idle
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h01,1'b1,1'b0,1'b0,1'b1,1'b0}, // R2 first packet
        '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h01,1'b0,1'b0,1'b0,1'b1,1'b0}, // R2 irq gone
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h03,1'b0,1'b0,1'b0,1'b0,1'b0}, // R3 full
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h03,1'b0,1'b0,1'b0,1'b0,1'b0}, // R3 dropped
        '{1'b1,8'h10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h01,1'b0,1'b0,1'b0,1'b0,1'b1}, // R4 flush one
        '{1'b1,8'h10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R4 flush two
        '{1'b1,8'h10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R4 flush empty
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h01,1'b1,1'b0,1'b0,1'b1,1'b0}, // R5 bulk bad pkt
        '{1'b1,8'h81,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h01,1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 clear toggle
        '{1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 unload
        '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h09,1'b1,1'b0,1'b0,1'b1,1'b0}, // R6 iso bad pkt
        '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h0D,1'b0,1'b0,1'b0,1'b1,1'b0}, // R7 refuse
        '{1'b1,8'h09,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h09,1'b0,1'b0,1'b0,1'b1,1'b0}, // R7 clear
        '{1'b1,8'h01,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h0D,1'b0,1'b0,1'b0,1'b1,1'b0}, // R7 hw wins
        '{1'b1,8'h01,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h09,1'b0,1'b0,1'b0,1'b1,1'b0}, // R7 clear again
        '{1'b1,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0,1'b0,1'b1,1'b0}, // R6 err clears
        '{1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h01,1'b1,1'b0,1'b0,1'b0,1'b0}, // R8 setup
        '{1'b1,8'h20,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h20,1'b0,1'b1,1'b0,1'b0,1'b0}, // R8 stall on
        '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h20,1'b0,1'b0,1'b0,1'b0,1'b0}, // R8 iso no stall
        '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h60,1'b0,1'b1,1'b0,1'b0,1'b0}, // R9 stall sent
        '{1'b1,8'h20,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h60,1'b0,1'b1,1'b0,1'b0,1'b0}, // R9 hw wins
        '{1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}, // R9 clear
        '{1'b1,8'h20,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h20,1'b0,1'b0,1'b1,1'b0,1'b0}, // R10 request
        '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h20,1'b0,1'b0,1'b0,1'b0,1'b0}, // R10 pulse ends
        '{1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h01,1'b1,1'b0,1'b0,1'b1,1'b0}, // R10 self clear
        '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h41,1'b1,1'b0,1'b0,1'b1,1'b0}, // R11 stall rx
        '{1'b1,8'h01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h01,1'b0,1'b0,1'b0,1'b1,1'b0}, // R11 clear
        '{1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,1'b0,1'b0,1'b0,1'b1,1'b0}, // R11 unload
        '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00,1'b0,1'b0,1'b0,1'b1,1'b0}  // R11 ignored
    };

    function automatic string req_of(int i);
        if (i == 0)       return "R1";
        else if (i <= 2)  return "R2";
        else if (i <= 4)  return "R3";
        else if (i <= 7)  return "R4";
        else if (i <= 10) return "R5";
        else if (i == 11 || i == 16) return "R6";
        else if (i <= 15) return "R7";
        else if (i <= 19) return "R8";
        else if (i <= 22) return "R9";
        else if (i <= 25) return "R10";
        else              return "R11";
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_data = '0; ev_pkt = 0; ev_pkt_bad = 0;
        ev_stall_tx = 0; ev_stall_rx = 0; ev_reject = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "rd_data", rd_data, 8'h00);
        chk("R1", "outputs", {3'b0, irq, stall_req, in_req, data_toggle, fifo_flush}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = TBL[i].we; wr_data = TBL[i].wd;
            host_mode = TBL[i].host; iso_mode = TBL[i].iso;
            ev_pkt = TBL[i].pkt; ev_pkt_bad = TBL[i].bad;
            ev_stall_tx = TBL[i].stx; ev_stall_rx = TBL[i].srx; ev_reject = TBL[i].rej;
            @(posedge clk);
            #1;
            chk(req_of(i), "rd_data", rd_data, TBL[i].rd);
            chk(req_of(i), "irq/stall/inreq/tog/flush",
                {3'b0, irq, stall_req, in_req, data_toggle, fifo_flush},
                {3'b0, TBL[i].irq, TBL[i].stl, TBL[i].inr, TBL[i].tog, TBL[i].fl});
        end

        // R12: unload and arrival in one cycle keep the count at one
        @(negedge clk);
        idle_inputs(); host_mode = 0; iso_mode = 0;
        ev_pkt = 1;                              // count 0 -> 1, toggle 1 -> 0
        @(posedge clk); #1;
        chk("R12", "rd_data setup", rd_data, 8'h01);
        @(negedge clk);
        ev_pkt = 1; wr_en = 1; wr_data = 8'h00;  // unload + arrival
        @(posedge clk); #1;
        chk("R12", "rd_data", rd_data, 8'h01);
        chk("R12", "irq", {7'b0, irq}, 8'h00);
        chk("R5", "toggle after arrival", {7'b0, data_toggle}, 8'h01);

        // R1: reset in the middle of activity
        @(negedge clk);
        idle_inputs();
        ev_pkt = 1;
        @(posedge clk); #1;
        chk("R3", "rd_data two stored", rd_data, 8'h03);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", "rd_data after reset", rd_data, 8'h00);
        chk("R1", "toggle after reset", {7'b0, data_toggle}, 8'h00);

        finish_run();
    end

endmodule